// File: doc/BRIEF.md
# Bit-Field Deposit and Extract Unit

This block moves a bit field into or out of a 32-bit word in one registered step. In deposit mode it writes a field into a background word: the field bits come from the upper half-word of the second operand, and the control half-word in its lower half gives the field's starting bit and its width. The field replaces the background bits it covers and all other background bits are kept. A sign-extending variant also overwrites every background bit above the field with the field's most significant bit.

In extract mode it reads a field out of a scene word. The field is taken at the position and width that the control half-word names, and it is returned right-aligned. The bits above the field are zero-filled or sign-filled, as the extension select chooses.

The result is registered, so it appears one clock edge after the operands are presented. A new operation can be issued on every cycle.

Top module: `bitfield_unit`

## Requirements
- R1: Deposit with `sext_i`=0 writes field bit k to result bit pos+k for k < len and copies every other bit of `opa_i` unchanged (all-ones background, zero pattern, pos 7, len 3 gives 0xFFFFFC7F).
- R2: Control fields live in `opb_i`: position in bits 15:8 and length in bits 4:0. For deposit, the pattern is in bits 31:16 and is zero-extended to 32 bits before its low len bits are taken. Bits 7:5 are ignored.
- R3: Deposit with `sext_i`=1 places the field as in R1, keeps the background bits below pos, and sets every bit at pos+len and above to pattern bit len-1 (all-ones background, pattern 0x5A5A, pos 7, len 3 gives 0x0000017F).
- R4: Extract with `sext_i`=0 returns scene bits pos+len-1..pos in result bits len-1..0, with zeros above (scene 0xA5A5C3AA, pos 7, len 4 gives 7).
- R5: Extract with `sext_i`=1 returns the same low len bits and fills every bit above them with result bit len-1 (scene 0xA5A5C3AA, pos 28, len 4 gives 0xFFFFFFFA; pos 7, len 4 gives 7).
- R6: Extract ignores `opb_i` bits 31:16 and bits 7:5.
- R7: A length of 0 gives a result of 0 for extract and `opa_i` unchanged for deposit, in both extension modes.
- R8: Field bits that would sit at or above bit 32 are dropped. For deposit they are discarded. For extract they read as zero, and they also supply the sign bit when the field runs past bit 31. A position of 32 or more therefore gives 0 on extract and leaves the background unchanged on deposit.
- R9: `result_o` updates on the rising clock edge after the operands are applied and holds between edges. An active-low asynchronous reset clears it to 0.
- R10: `op_i`=0 selects deposit and `op_i`=1 selects extract. `sext_i`=1 selects the sign-extending variant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opa_i | input | 32 | Background word (deposit) or scene word (extract) |
| opb_i | input | 32 | Pattern in 31:16, position in 15:8, length in 4:0 |
| op_i | input | 1 | 0 = deposit, 1 = extract |
| sext_i | input | 1 | 1 = sign-extending variant |
| result_o | output | 32 | Registered result |

## Verification
The hardest cases to reach are fields that straddle bit 31. In those cases the sign source of an extract is a bit that does not exist, and a sign-extending deposit has no room above the field to fill. Random operands rarely land there, because positions are drawn from 0 to 255. Dedicated tasks therefore drive positions 28 to 40 with lengths that overrun the word. Zero-length controls are driven together with the sign select set, to show that the fill region stays untouched. Randomized vectors biased toward small positions are compared against a bit-by-bit model written in the bench.

// File: rtl/bfu_pkg.sv
`timescale 1ns/1ps
package bfu_pkg;
   typedef enum logic {
      BFU_DEPOSIT = 1'b0,
      BFU_EXTRACT = 1'b1
   } bfu_op_e;
endpackage

// File: rtl/bfu_ctrl_decode.sv
`timescale 1ns/1ps
// Splits the control half-word and builds per-bit region masks.
module bfu_ctrl_decode #(
   parameter int DATA_W  = 32,
   parameter int POS_W   = 8,
   parameter int LEN_W   = 5
) (
   input  logic [POS_W-1:0]  pos_i,
   input  logic [LEN_W-1:0]  len_i,
   output logic              len_nz_o,
   output logic [DATA_W-1:0] below_m_o,
   output logic [DATA_W-1:0] field_m_o,
   output logic [DATA_W-1:0] above_m_o,
   output logic [DATA_W-1:0] keep_m_o
);
   localparam int SUM_W  = POS_W + 1;
   localparam int KLEN_W = LEN_W + 1;

   logic [SUM_W-1:0] start_w;
   logic [SUM_W-1:0] end_w;

   assign start_w  = {1'b0, pos_i};
   assign end_w    = start_w + SUM_W'(len_i);
   assign len_nz_o = |len_i;

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      assign below_m_o[i] = SUM_W'(i) <  start_w;
      assign above_m_o[i] = SUM_W'(i) >= end_w;
      assign field_m_o[i] = !below_m_o[i] && !above_m_o[i];
      assign keep_m_o[i]  = KLEN_W'(i) < {1'b0, len_i};
   end
endmodule

// File: rtl/bfu_deposit.sv
`timescale 1ns/1ps
// Inserts the low len pattern bits at pos, optional sign fill above.
module bfu_deposit #(
   parameter int DATA_W = 32,
   parameter int PAT_W  = 16,
   parameter int POS_W  = 8,
   parameter int LEN_W  = 5
) (
   input  logic [DATA_W-1:0] bg_i,
   input  logic [PAT_W-1:0]  pat_i,
   input  logic [POS_W-1:0]  pos_i,
   input  logic [LEN_W-1:0]  len_i,
   input  logic              len_nz_i,
   input  logic              sext_i,
   input  logic [DATA_W-1:0] field_m_i,
   input  logic [DATA_W-1:0] above_m_i,
   output logic [DATA_W-1:0] dep_o
);
   logic [DATA_W-1:0] pat_ext;
   logic [DATA_W-1:0] placed;
   logic [DATA_W-1:0] fill_m;
   logic              top_bit;

   assign pat_ext = DATA_W'(pat_i);
   assign placed  = pat_ext << pos_i;
   assign top_bit = pat_ext[len_i - 1'b1];
   assign fill_m  = (sext_i && len_nz_i) ? above_m_i : '0;

   always_comb begin
      dep_o = (bg_i & ~(field_m_i | fill_m)) | (placed & field_m_i);
      if (top_bit) dep_o = dep_o | fill_m;
   end
endmodule

// File: rtl/bfu_extract.sv
`timescale 1ns/1ps
// Pulls len bits from pos, right-aligns them, zero or sign fills above.
module bfu_extract #(
   parameter int DATA_W = 32,
   parameter int POS_W  = 8,
   parameter int LEN_W  = 5
) (
   input  logic [DATA_W-1:0] scene_i,
   input  logic [POS_W-1:0]  pos_i,
   input  logic [LEN_W-1:0]  len_i,
   input  logic              len_nz_i,
   input  logic              sext_i,
   input  logic [DATA_W-1:0] keep_m_i,
   output logic [DATA_W-1:0] ext_o
);
   logic [DATA_W-1:0] shifted;
   logic              top_bit;

   assign shifted = scene_i >> pos_i;
   assign top_bit = shifted[len_i - 1'b1];

   always_comb begin
      ext_o = shifted & keep_m_i;
      if (sext_i && len_nz_i && top_bit) ext_o = ext_o | ~keep_m_i;
   end
endmodule

// File: rtl/bitfield_unit.sv
`timescale 1ns/1ps
module bitfield_unit #(
   parameter int DATA_W = 32,
   parameter int POS_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] opa_i,
   input  logic [DATA_W-1:0] opb_i,
   input  logic              op_i,
   input  logic              sext_i,
   output logic [DATA_W-1:0] result_o
);
   import bfu_pkg::*;

   localparam int CTRL_W  = DATA_W / 2;
   localparam int LEN_W   = $clog2(DATA_W);
   localparam int POS_LSB = CTRL_W / 2;

   if ((DATA_W & (DATA_W - 1)) != 0 || DATA_W < 16) begin : g_bad_width
      $error("bitfield_unit: DATA_W must be a power of two of at least 16");
   end
   if (POS_LSB < LEN_W || POS_LSB + POS_W > CTRL_W || POS_W <= LEN_W) begin : g_bad_ctrl
      $error("bitfield_unit: control fields do not fit the control half-word");
   end

   logic [POS_W-1:0]  pos;
   logic [LEN_W-1:0]  len;
   logic              len_nz;
   logic [DATA_W-1:0] below_m, field_m, above_m, keep_m;
   logic [DATA_W-1:0] dep_res, ext_res, next_res;
   bfu_op_e           op_sel;

   assign pos    = opb_i[POS_LSB +: POS_W];
   assign len    = opb_i[LEN_W-1:0];
   assign op_sel = bfu_op_e'(op_i);

   bfu_ctrl_decode #(.DATA_W(DATA_W), .POS_W(POS_W), .LEN_W(LEN_W)) u_dec (
      .pos_i(pos), .len_i(len), .len_nz_o(len_nz),
      .below_m_o(below_m), .field_m_o(field_m),
      .above_m_o(above_m), .keep_m_o(keep_m)
   );

   bfu_deposit #(.DATA_W(DATA_W), .PAT_W(CTRL_W), .POS_W(POS_W), .LEN_W(LEN_W)) u_dep (
      .bg_i(opa_i), .pat_i(opb_i[DATA_W-1:CTRL_W]), .pos_i(pos), .len_i(len),
      .len_nz_i(len_nz), .sext_i(sext_i), .field_m_i(field_m),
      .above_m_i(above_m), .dep_o(dep_res)
   );

   bfu_extract #(.DATA_W(DATA_W), .POS_W(POS_W), .LEN_W(LEN_W)) u_ext (
      .scene_i(opa_i), .pos_i(pos), .len_i(len), .len_nz_i(len_nz),
      .sext_i(sext_i), .keep_m_i(keep_m), .ext_o(ext_res)
   );

   assign next_res = (op_sel == BFU_EXTRACT) ? ext_res : dep_res;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) result_o <= '0;
      else        result_o <= next_res;
   end

   // R7: zero length
   assert_ext_len0_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i && len == '0) |=> result_o == '0);
   assert_dep_len0_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_i && len == '0) |=> result_o == $past(opa_i));
   // R8: field entirely beyond the word
   assert_ext_far_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i && pos >= POS_W'(DATA_W)) |=> result_o == '0);
   // R4: zero-extended extract clears bits above the field
   assert_ext_zero_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i && !sext_i && len != '0) |=> (result_o >> $past(len)) == '0);
   // R5: sign-extended extract replicates the field top bit
   assert_ext_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i && sext_i && len != '0) |=> result_o[DATA_W-1] == result_o[$past(len) - 1'b1]);
   // R1: deposit keeps background bits below the field
   assert_dep_below_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_i) |=> ((result_o ^ $past(opa_i)) & $past(below_m)) == '0);
endmodule

// File: tb/bitfield_unit_bench.sv
`timescale 1ns/1ps
module bitfield_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] opa = '0, opb = '0;
   logic        op = 1'b0, sext = 1'b0;
   logic [31:0] result;
   int          total = 0;
   int          bad = 0;
   bit          finished = 1'b0;

   always #2 clk = ~clk;

   bitfield_unit u_bitfield_unit (
      .clk(clk), .rst_n(rst_n), .opa_i(opa), .opb_i(opb),
      .op_i(op), .sext_i(sext), .result_o(result)
   );

   task automatic check(string req, logic [31:0] got, logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got=%08h expected=%08h", req, got, exp);
      end
   endtask

   // Bit-by-bit model written from the requirements.
   function automatic logic [31:0] model(logic [31:0] a, logic [31:0] b, logic o, logic sx);
      int p = int'(b[15:8]);
      int n = int'(b[4:0]);
      logic [31:0] pat = {16'h0, b[31:16]};
      logic [31:0] r;
      if (!o) begin
         r = a;
         if (n == 0) return r;
         for (int k = 0; k < n; k++) if (p + k < 32) r[p+k] = pat[k];
         if (sx) for (int d = p + n; d < 32; d++) r[d] = pat[n-1];
      end else begin
         r = '0;
         if (n == 0) return r;
         for (int k = 0; k < n; k++) r[k] = (p + k < 32) ? a[p+k] : 1'b0;
         if (sx) for (int k = n; k < 32; k++) r[k] = r[n-1];
      end
      return r;
   endfunction

   task automatic run(logic [31:0] a, logic [31:0] b, logic o, logic sx, output logic [31:0] r);
      @(negedge clk);
      opa = a; opb = b; op = o; sext = sx;
      @(posedge clk);
      #1 r = result;
   endtask

   task automatic t_reset();
      #1 check("R9 reset", result, 32'h0);
      @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic t_deposit_plain();
      logic [31:0] r;
      run(32'hFFFF_FFFF, 32'h0000_0703, 1'b0, 1'b0, r); check("R1 deposit zero pattern", r, 32'hFFFF_FC7F);
      run(32'h0000_0000, 32'hABCD_0408, 1'b0, 1'b0, r); check("R2 deposit pattern bits", r, 32'h0000_0CD0);
      run(32'h0000_0000, 32'hABCD_04E8, 1'b0, 1'b0, r); check("R2 deposit ignores 7:5", r, 32'h0000_0CD0);
      run(32'h1111_1111, 32'h00AB_1008, 1'b0, 1'b0, r); check("R10 op 0 is deposit", r, 32'h11AB_1111);
   endtask

   task automatic t_deposit_sign();
      logic [31:0] r;
      run(32'hFFFF_FFFF, 32'h5A5A_0703, 1'b0, 1'b1, r); check("R3 sign deposit positive", r, 32'h0000_017F);
      run(32'h1234_5678, 32'h000F_1004, 1'b0, 1'b1, r); check("R3 sign deposit negative", r, 32'hFFFF_5678);
   endtask

   task automatic t_extract();
      logic [31:0] r;
      run(32'hA5A5_C3AA, 32'h0000_0704, 1'b1, 1'b0, r); check("R4 extract zero", r, 32'h7);
      run(32'hA5A5_C3AA, 32'h0000_0704, 1'b1, 1'b1, r); check("R5 extract sign positive", r, 32'h7);
      run(32'hA5A5_C3AA, 32'h0000_1C04, 1'b1, 1'b1, r); check("R5 extract sign negative", r, 32'hFFFF_FFFA);
      run(32'hA5A5_C3AA, 32'h0000_1C04, 1'b1, 1'b0, r); check("R4 extract zero high nibble", r, 32'h0000_000A);
      run(32'hA5A5_C3AA, 32'hDEAD_07E4, 1'b1, 1'b0, r); check("R6 extract ignores upper and 7:5", r, 32'h7);
   endtask

   task automatic t_zero_len();
      logic [31:0] r;
      run(32'hFFFF_FFFF, 32'h0000_0700, 1'b1, 1'b1, r); check("R7 extract len 0", r, 32'h0);
      run(32'h1357_9BDF, 32'hFFFF_0A00, 1'b0, 1'b1, r); check("R7 sign deposit len 0", r, 32'h1357_9BDF);
      run(32'h1357_9BDF, 32'hFFFF_0A00, 1'b0, 1'b0, r); check("R7 deposit len 0", r, 32'h1357_9BDF);
   endtask

   task automatic t_overflow();
      logic [31:0] r;
      run(32'h0000_0000, 32'hFFFF_1E08, 1'b0, 1'b1, r); check("R8 deposit past bit 31", r, 32'hC000_0000);
      run(32'hF000_0000, 32'h0000_1E08, 1'b1, 1'b1, r); check("R8 extract past bit 31", r, 32'h0000_0003);
      run(32'hFFFF_FFFF, 32'h0000_2804, 1'b1, 1'b1, r); check("R8 extract pos 40", r, 32'h0);
      run(32'h2468_ACE0, 32'hFFFF_2004, 1'b0, 1'b1, r); check("R8 deposit pos 32", r, 32'h2468_ACE0);
   endtask

   task automatic t_latency();
      logic [31:0] r;
      run(32'hA5A5_C3AA, 32'h0000_0704, 1'b1, 1'b0, r);
      @(negedge clk);
      opa = 32'hFFFF_FFFF; opb = 32'h0000_0703; op = 1'b0; sext = 1'b0;
      #1 check("R9 holds before edge", result, 32'h7);
      @(posedge clk);
      #1 check("R9 updates after edge", result, 32'hFFFF_FC7F);
   endtask

   task automatic t_random();
      logic [31:0] r;
      for (int i = 0; i < 400; i++) begin
         logic [31:0] a = $urandom;
         logic [31:0] b = $urandom;
         logic o = 1'($urandom);
         logic sx = 1'($urandom);
         if (i % 4 != 0) b[15:8] = 8'($urandom_range(0, 36));
         run(a, b, o, sx, r);
         check(o ? "R10 random extract" : "R10 random deposit", r, model(a, b, o, sx));
      end
   endtask

   initial begin
      #20000;
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: got=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_deposit_plain();
      t_deposit_sign();
      t_extract();
      t_zero_len();
      t_overflow();
      t_latency();
      t_random();
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule